// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block serves one external interrupt pin of a small microcontroller core. While the core runs, the pin is synchronized and a high-to-low transition raises a sticky request flag. The flag rises whatever the state of the enables. Software reads the flag and clears it by writing zero. The controller combines the flag with a local enable and a global enable. When all three are set, it issues a one-cycle take pulse toward the core and presents a fixed vector address of 8. Accepting the interrupt drops the global enable, and a return-from-interrupt strobe raises it again.

While the core sleeps, in either power-down or low-speed idle mode, the normal clocked detection path is masked. A falling pin edge is then caught by an edge-clocked latch that needs no running clock, and that latch raises a wake request toward power control. When the core leaves sleep, the latched wake event sets the request flag on the first clock edge. The latch is then cleared, so with both enables set the vector is taken at once.

Top module: `extint_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, `flag_o`, `ien_o`, `gie_o`, `take_o` and `wake_o` are all 0.
- R2: While `sleep_i` is 0, a fall of `pin_i` from 1 to 0 (held low, driven between clock edges) sets `flag_o` at the third rising clock edge after the fall. This happens whatever `ien_o` and `gie_o` hold. Once set, `flag_o` stays 1 until software clears it.
- R3: `take_o` is 1 only in cycles where `flag_o`, `ien_o` and `gie_o` are all 1 and `sleep_i` is 0. It lasts exactly one cycle per acceptance.
- R4: `vec_o` always presents the value 8.
- R5: The clock edge that ends a `take_o` cycle clears `gie_o`. A cycle with `reti_i` at 1 sets `gie_o` at the next edge. `ien_wr_i`/`ien_wd_i` and `gie_wr_i`/`gie_wd_i` load the enables.
- R6: A cycle with `flag_wr_i`=1 and `flag_wd_i`=0 clears `flag_o` at the next edge. A write with `flag_wd_i`=1 has no effect on `flag_o`.
- R7: When a hardware set of the flag and a software clear fall in the same cycle, `flag_o` is 1 afterwards.
- R8: A rise of `pin_i`, or a pin held steady, never sets `flag_o`.
- R9: While `sleep_i` is 1, a fall of `pin_i` raises `wake_o` without a clock edge, even for a low pulse shorter than a clock period. In that state the clocked detection path does not set `flag_o`, and `take_o` stays 0.
- R10: A wake event latched during sleep sets `flag_o` at the first rising edge after `sleep_i` returns to 0, and `wake_o` is 0 again after that edge.
- R11: A fall of `pin_i` while `sleep_i` is 0 leaves `wake_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous, idle high |
| sleep_i | input | 1 | Core is in power-down or low-speed idle mode |
| ien_wr_i | input | 1 | Write strobe for the local enable |
| ien_wd_i | input | 1 | Local enable write data |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wd_i | input | 1 | Global enable write data |
| flag_wr_i | input | 1 | Write strobe for the request flag |
| flag_wd_i | input | 1 | Flag write data; only 0 acts (clear) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| flag_o | output | 1 | Sticky request flag |
| ien_o | output | 1 | Local enable |
| gie_o | output | 1 | Global enable |
| take_o | output | 1 | One-cycle interrupt acceptance pulse |
| vec_o | output | 8 | Vector address |
| wake_o | output | 1 | Asynchronous wake request to power control |

## Verification
A pin edge setting the flag and a software write clearing it can land in the same cycle. The flag must come out set, so that no edge is lost. The bench provokes this by dropping the pin and then placing the clear strobe in the cycle before the third rising edge, which is the edge where the detected fall reaches the flag. It then reads `flag_o` after that edge and expects 1. A second overlap is a wake event being absorbed on the same edge where the take pulse becomes possible. The bench judges it by sampling `flag_o`, `take_o` and `wake_o` together in the first cycle after sleep ends.

// File: rtl/extint_pkg.sv
// Package: shared defaults and the state record of the interrupt controller.
// Assumes: nothing beyond standard SystemVerilog.
package extint_pkg;
    localparam int unsigned EXTINT_SYNC_STAGES = 2;
    localparam int unsigned EXTINT_VEC_W       = 8;
    localparam int unsigned EXTINT_VEC_ADDR    = 8;

    // Software-visible state bits of the controller.
    typedef struct packed {
        logic flag;
        logic ien;
        logic gie;
    } extint_state_t;
endpackage

// File: rtl/extint_sync.sv
// Module: multi-stage synchronizer for a single asynchronous bit.
// Assumes: STAGES >= 1; the reset value is the input's idle level.
module extint_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous input.
            always_ff @(posedge clk_i) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d_i;
            end
        end else begin : g_next
            // Later stages resolve metastability of the previous stage.
            always_ff @(posedge clk_i) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/extint_fall_det.sv
// Module: clocked falling-edge detector for the interrupt pin.
// Assumes: pin idles high; detection is masked while the core sleeps.
module extint_fall_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pin_i,
    input  logic mask_i,
    output logic fall_o
);
    logic pin_s;
    logic pin_prev;

    extint_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    // Hold the previous synchronized pin level for edge comparison.
    always_ff @(posedge clk_i) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_s;
    end

    assign fall_o = pin_prev & ~pin_s & ~mask_i;
endmodule

// File: rtl/extint_wake.sv
// Module: sleep-time wake capture. An edge-clocked latch records a pin fall
// while asleep; the clock domain absorbs it once after wake and clears it.
// Assumes: sleep_i is stable around pin edges while asleep.
module extint_wake #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic pin_i,
    input  logic sleep_i,
    output logic wake_o,
    output logic set_o
);
    logic lat_q;
    logic lat_s;
    logic clr_q;
    logic done_q;

    // Capture a pin fall without a clock; cleared from the clock domain.
    always_ff @(negedge pin_i or posedge clr_q) begin
        if (clr_q) lat_q <= 1'b0;
        else       lat_q <= sleep_i;
    end

    extint_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_lat_sync (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .d_i   (lat_q),
        .q_o   (lat_s)
    );

    assign set_o  = lat_s & ~sleep_i & ~done_q;
    assign wake_o = lat_q;

    // Issue the latch clear and remember the event was consumed.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            clr_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            clr_q  <= set_o;
            done_q <= lat_s & (done_q | set_o);
        end
    end
endmodule

// File: rtl/extint_regs.sv
// Module: request flag, local and global enables, and acceptance pulse.
// Assumes: hardware set of the flag takes priority over a software clear.
module extint_regs
    import extint_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic sleep_i,
    input  logic ien_wr_i,
    input  logic ien_wd_i,
    input  logic gie_wr_i,
    input  logic gie_wd_i,
    input  logic flag_wr_i,
    input  logic flag_wd_i,
    input  logic reti_i,
    output extint_state_t st_o,
    output logic take_o
);
    extint_state_t st_q;

    assign take_o = st_q.flag & st_q.ien & st_q.gie & ~sleep_i;

    // Update flag and enables; set beats clear, acceptance beats writes.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            if (hw_set_i)                    st_q.flag <= 1'b1;
            else if (flag_wr_i && !flag_wd_i) st_q.flag <= 1'b0;

            if (ien_wr_i) st_q.ien <= ien_wd_i;

            if (take_o)        st_q.gie <= 1'b0;
            else if (reti_i)   st_q.gie <= 1'b1;
            else if (gie_wr_i) st_q.gie <= gie_wd_i;
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/extint_ctrl.sv
// Module: top of the single-pin external interrupt controller.
// Assumes: pin idles high; trigger is the falling edge only; the clock runs
// in any cycle where the flag or enables are written.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = EXTINT_SYNC_STAGES,
    parameter int unsigned VEC_W       = EXTINT_VEC_W,
    parameter int unsigned VEC_ADDR    = EXTINT_VEC_ADDR
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             sleep_i,
    input  logic             ien_wr_i,
    input  logic             ien_wd_i,
    input  logic             gie_wr_i,
    input  logic             gie_wd_i,
    input  logic             flag_wr_i,
    input  logic             flag_wd_i,
    input  logic             reti_i,
    output logic             flag_o,
    output logic             ien_o,
    output logic             gie_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             wake_o
);
    logic          fall;
    logic          wake_set;
    logic          hw_set;
    extint_state_t st;

    extint_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mask_i (sleep_i),
        .fall_o (fall)
    );

    extint_wake #(.STAGES(SYNC_STAGES)) u_wake (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .sleep_i (sleep_i),
        .wake_o  (wake_o),
        .set_o   (wake_set)
    );

    assign hw_set = fall | wake_set;

    extint_regs u_regs (
        .clk_i     (clk_i),
        .rst_n     (rst_n),
        .hw_set_i  (hw_set),
        .sleep_i   (sleep_i),
        .ien_wr_i  (ien_wr_i),
        .ien_wd_i  (ien_wd_i),
        .gie_wr_i  (gie_wr_i),
        .gie_wd_i  (gie_wd_i),
        .flag_wr_i (flag_wr_i),
        .flag_wd_i (flag_wd_i),
        .reti_i    (reti_i),
        .st_o      (st),
        .take_o    (take_o)
    );

    assign flag_o = st.flag;
    assign ien_o  = st.ien;
    assign gie_o  = st.gie;
    assign vec_o  = VEC_W'(VEC_ADDR);
endmodule

// File: rtl/extint_ctrl_chk.sv
// Module: property checker for extint_ctrl, attached by bind below.
// Assumes: hw_set is the top's combined hardware flag-set signal.
module extint_ctrl_chk (
    input logic clk_i,
    input logic rst_n,
    input logic flag_wr_i,
    input logic flag_wd_i,
    input logic reti_i,
    input logic flag_o,
    input logic gie_o,
    input logic take_o,
    input logic hw_set
);
    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        take_o |=> !take_o); // R3
    AST_GIE_DROP_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_n)
        take_o |=> !gie_o); // R5
    AST_RETI_RESTORES_GIE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (reti_i && !take_o) |=> gie_o); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
        (flag_o && !(flag_wr_i && !flag_wd_i)) |=> flag_o); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
        hw_set |=> flag_o); // R7
    AST_WRITE_ONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!flag_o && flag_wr_i && flag_wd_i && !hw_set) |=> !flag_o); // R6
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .flag_wr_i (flag_wr_i),
    .flag_wd_i (flag_wd_i),
    .reti_i    (reti_i),
    .flag_o    (flag_o),
    .gie_o     (gie_o),
    .take_o    (take_o),
    .hw_set    (hw_set)
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b1;
    logic       sleep_i = 1'b0;
    logic       ien_wr_i = 1'b0, ien_wd_i = 1'b0;
    logic       gie_wr_i = 1'b0, gie_wd_i = 1'b0;
    logic       flag_wr_i = 1'b0, flag_wd_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       flag_o, ien_o, gie_o, take_o, wake_o;
    logic [7:0] vec_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    extint_ctrl u_dut (
        .clk_i(clk_i), .rst_n(rst_n), .pin_i(pin_i), .sleep_i(sleep_i),
        .ien_wr_i(ien_wr_i), .ien_wd_i(ien_wd_i),
        .gie_wr_i(gie_wr_i), .gie_wd_i(gie_wd_i),
        .flag_wr_i(flag_wr_i), .flag_wd_i(flag_wd_i), .reti_i(reti_i),
        .flag_o(flag_o), .ien_o(ien_o), .gie_o(gie_o), .take_o(take_o),
        .vec_o(vec_o), .wake_o(wake_o)
    );

    // Row fields: {ien, gie, fall, expected flag, expected take}
    localparam logic [4:0] TBL [6] = '{
        5'b11111, 5'b01110, 5'b10110, 5'b00110, 5'b11000, 5'b01000
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic wr_ien(input logic v);
        @(negedge clk_i); ien_wr_i = 1'b1; ien_wd_i = v;
        @(negedge clk_i); ien_wr_i = 1'b0;
    endtask

    task automatic wr_gie(input logic v);
        @(negedge clk_i); gie_wr_i = 1'b1; gie_wd_i = v;
        @(negedge clk_i); gie_wr_i = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        @(negedge clk_i); flag_wr_i = 1'b1; flag_wd_i = v;
        @(negedge clk_i); flag_wr_i = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk_i); reti_i = 1'b1;
        @(negedge clk_i); reti_i = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cycles(3);
        // R1: reset state
        check("R1 flag", flag_o, 0);
        check("R1 ien", ien_o, 0);
        check("R1 gie", gie_o, 0);
        check("R1 take", take_o, 0);
        check("R1 wake", wake_o, 0);
        rst_n = 1'b1;
        cycles(2);
        check("R4 vector", vec_o, 8);

        // Table walk: enable combinations with and without a falling edge
        foreach (TBL[i]) begin
            wr_flag(1'b0);
            wr_ien(TBL[i][4]);
            wr_gie(TBL[i][3]);
            cycles(2);
            if (TBL[i][2]) pin_i = 1'b0;
            cycles(3);
            check($sformatf("R2 flag row %0d", i), flag_o, TBL[i][1]);
            check($sformatf("R3 take row %0d", i), take_o, TBL[i][0]);
            check($sformatf("R11 wake row %0d", i), wake_o, 0);
            cycles(1);
            check($sformatf("R3 single pulse row %0d", i), take_o, 0);
            check($sformatf("R5 gie row %0d", i), gie_o, TBL[i][3] & ~TBL[i][0]);
            pin_i = 1'b1;
            cycles(4);
            check($sformatf("R2 flag held row %0d", i), flag_o, TBL[i][1]);
            pulse_reti();
            check($sformatf("R5 reti row %0d", i), gie_o, 1);
            wr_gie(1'b0);
        end

        // R6: clear works, write of 1 is ignored
        wr_ien(1'b0);
        pin_i = 1'b0;
        cycles(4);
        check("R2 flag before clear", flag_o, 1);
        wr_flag(1'b0);
        check("R6 cleared", flag_o, 0);
        wr_flag(1'b1);
        check("R6 write one ignored", flag_o, 0);

        // R8: rising edge does not set the flag
        pin_i = 1'b1;
        cycles(5);
        check("R8 rise no set", flag_o, 0);
        cycles(5);
        check("R8 steady no set", flag_o, 0);

        // R7: set and clear in the same cycle, set wins
        pin_i = 1'b0;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        flag_wr_i = 1'b1; flag_wd_i = 1'b0;
        @(negedge clk_i);
        flag_wr_i = 1'b0;
        check("R7 set beats clear", flag_o, 1);
        pin_i = 1'b1;
        cycles(4);
        wr_flag(1'b0);

        // R9/R10: long low pulse during sleep, then wake
        wr_ien(1'b1);
        wr_gie(1'b1);
        sleep_i = 1'b1;
        cycles(2);
        pin_i = 1'b0;
        #1;
        check("R9 wake async", wake_o, 1);
        cycles(5);
        check("R9 no clocked set asleep", flag_o, 0);
        check("R9 no take asleep", take_o, 0);
        pin_i = 1'b1;
        cycles(3);
        sleep_i = 1'b0;
        cycles(1);
        check("R10 flag after wake", flag_o, 1);
        check("R10 take after wake", take_o, 1);
        check("R10 wake cleared", wake_o, 0);
        cycles(1);
        check("R3 take once after wake", take_o, 0);
        cycles(5);
        wr_flag(1'b0);
        check("R10 flag clearable", flag_o, 0);

        // R9: glitch shorter than a clock period while asleep
        sleep_i = 1'b1;
        cycles(2);
        #1 pin_i = 1'b0;
        #2 pin_i = 1'b1;
        #1;
        check("R9 glitch wake", wake_o, 1);
        cycles(4);
        check("R9 glitch no flag asleep", flag_o, 0);
        sleep_i = 1'b0;
        cycles(1);
        check("R10 glitch flag after wake", flag_o, 1);
        check("R10 glitch wake cleared", wake_o, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule